// File: doc/BRIEF.md
# HDLC Receive Frame Extractor

This block sits behind a bit-serial receiver and turns a synchronous bit stream into host-readable frame bytes. A strobe qualifies each incoming bit. The block finds flag symbols (the octet 0x7E) and abort symbols (runs of seven or more ones). It deletes the zero that the transmitter inserted after every five consecutive ones, and it packs the remaining bits into bytes, least significant bit first. It also runs a CRC-16 check over each frame.

Every frame byte reaches the host through a one-deep holding register. A two-bit status travels with each byte: an end-of-frame bit and an error bit. The two CRC bytes at the tail of a frame are never delivered. The last real data byte is held back until the closing flag arrives, so it can carry the end-of-frame status together with the outcome of the CRC check. A ready flag marks each delivered byte, and an optional interrupt follows that flag. The host reads the status first and then the data. The data read clears the ready flag, and after that read the status may be replaced by the next delivery.

Framing stays off after reset until the enable input is set. The enable only takes effect at the next flag.

Top module: `hdlc_rx_extract`

## Requirements
- R1: After reset `rxi`, `irq`, `st_eof`, `st_err` and `rx_data` are all 0.
- R2: A flag is the raw bit sequence 0,1,1,1,1,1,1,0 (octet 0x7E on the line). Each flag closes any open frame and opens a new one. Consecutive flags produce no delivery.
- R3: Inside a frame, a 0 bit that directly follows five consecutive 1 bits is dropped before bytes are assembled.
- R4: Bits are packed into bytes with the first received bit at bit 0. Each data byte is delivered with `st_eof`=0 and `st_err`=0. The last two bytes before the closing flag (the CRC) are never delivered.
- R5: On a closing flag with a CRC-16 (reflected polynomial 0x8408, preset 0xFFFF) residue of 0xF0B8, the final data byte is delivered with `st_eof`=1 and `st_err`=0.
- R6: On a closing flag with any other residue, the final data byte is delivered with `st_eof`=1 and `st_err`=1.
- R7: If the number of destuffed bits between the flags is not a multiple of 8, the final delivery carries `st_eof`=1 and `st_err`=1.
- R8: Seven or more consecutive 1 bits form an abort. An abort that arrives after at least one byte of the frame has been delivered produces one delivery with data 0x00, `st_eof`=1 and `st_err`=1. An abort that arrives before any delivery is silent. After an abort, nothing is delivered until a flag appears.
- R9: A frame with fewer than three whole bytes between flags produces no delivery and no error.
- R10: `rxi` is set by every delivery and cleared by `rd_data`. If both happen in the same cycle, the delivery wins. Data and status hold their values until the next delivery.
- R11: `irq` equals `irq_en` AND `rxi`.
- R12: While `rx_enable` is 0 nothing is delivered. A frame is received only if it starts with a flag that arrives while `rx_enable` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_enable | input | 1 | Enables frame reception |
| bit_valid | input | 1 | Qualifies `bit_in` for one cycle |
| bit_in | input | 1 | Received line bit |
| irq_en | input | 1 | Interrupt enable |
| rd_data | input | 1 | Host read strobe for the data register, clears `rxi` |
| rx_data | output | 8 | Delivered byte |
| st_eof | output | 1 | End-of-frame status of the delivered byte |
| st_err | output | 1 | Error status of the delivered byte |
| rxi | output | 1 | Byte ready |
| irq | output | 1 | Interrupt request |

## Verification
The collision of interest is a host data read landing on the same edge as a new delivery. In that case `rxi` must stay set and the new byte must not be lost. The bench provokes this by holding `rd_data` high for a whole frame, so that every delivery edge coincides with a read. It then expects `rxi` to be seen high for exactly one cycle per delivery, with the correct byte and status, and `irq` to follow it.

// File: rtl/hdlc_rx_extract.sv
`timescale 1ns/1ps
module hdlc_rx_extract #(
  parameter logic [15:0] CRC_INIT = 16'hFFFF,
  parameter logic [15:0] CRC_POLY = 16'h8408,
  parameter logic [15:0] CRC_GOOD = 16'hF0B8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_enable,
  input  logic       bit_valid,
  input  logic       bit_in,
  input  logic       irq_en,
  input  logic       rd_data,
  output logic [7:0] rx_data,
  output logic       st_eof,
  output logic       st_err,
  output logic       rxi,
  output logic       irq
);

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++)
      r = (r >> 1) ^ ((r[0] ^ b[i]) ? CRC_POLY : 16'h0000);
    return r;
  endfunction

  logic [2:0]  ones;
  logic [2:0]  bitpos;
  logic [7:0]  asmb;
  logic [15:0] crc;
  logic [7:0]  p0, p1, p2;
  logic [1:0]  pcnt;
  logic        in_frame, sent;

  wire        flag      = bit_valid && !bit_in && ones == 3'd6;
  wire        abort     = bit_valid &&  bit_in && ones == 3'd6;
  wire        acc       = bit_valid && in_frame && ones < 3'd5;
  wire        byte_done = acc && bitpos == 3'd7;
  wire [7:0]  nbyte     = {bit_in, asmb[7:1]};

  wire deliver_data  = byte_done && pcnt == 2'd3;
  wire deliver_close = flag && in_frame && pcnt == 2'd3;
  wire deliver_abort = abort && in_frame && sent;
  wire deliver       = deliver_data || deliver_close || deliver_abort;
  wire close_bad     = bitpos != 3'd6 || crc != CRC_GOOD;

  assign irq = irq_en && rxi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ones <= '0;
    end else if (bit_valid) begin
      if (!bit_in)               ones <= '0;
      else if (ones != 3'd7)     ones <= ones + 3'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame <= 1'b0;
      sent     <= 1'b0;
      bitpos   <= '0;
      asmb     <= '0;
      crc      <= CRC_INIT;
      p0 <= '0; p1 <= '0; p2 <= '0;
      pcnt     <= '0;
    end else if (!rx_enable) begin
      in_frame <= 1'b0;
    end else if (flag) begin
      in_frame <= 1'b1;
      sent     <= 1'b0;
      bitpos   <= '0;
      crc      <= CRC_INIT;
      pcnt     <= '0;
    end else if (abort) begin
      in_frame <= 1'b0;
    end else if (acc) begin
      asmb   <= nbyte;
      bitpos <= bitpos + 3'd1;
      if (byte_done) begin
        crc  <= crc_step(crc, nbyte);
        p2   <= p1;
        p1   <= p0;
        p0   <= nbyte;
        if (pcnt != 2'd3) pcnt <= pcnt + 2'd1;
        else              sent <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data <= '0;
      st_eof  <= 1'b0;
      st_err  <= 1'b0;
      rxi     <= 1'b0;
    end else if (deliver) begin
      rx_data <= deliver_abort ? 8'h00 : p2;
      st_eof  <= !deliver_data;
      st_err  <= deliver_abort || (deliver_close && close_bad);
      rxi     <= 1'b1;
    end else if (rd_data) begin
      rxi     <= 1'b0;
    end
  end

  assert_flag_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && rx_enable) |=> (in_frame && pcnt == 2'd0 && !sent));

  assert_stuff_dropped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && ones == 3'd5) |=> $stable(asmb) && $stable(bitpos));

  assert_one_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({deliver_data, deliver_close, deliver_abort}));

  assert_abort_discards_R8: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !in_frame);

  assert_delivery_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    deliver |=> rxi);

  assert_read_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && !deliver) |=> !rxi);

  assert_status_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!deliver && !rd_data) |=> $stable({rx_data, st_eof, st_err, rxi}));

  assert_disabled_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_enable |=> !in_frame);

endmodule

// File: tb/hdlc_rx_extract_bench.sv
`timescale 1ns/1ps
module hdlc_rx_extract_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_enable = 1'b0, bit_valid = 1'b0, bit_in = 1'b0, irq_en = 1'b0;
  logic rd_auto = 1'b0, rd_hold = 1'b0;
  logic [7:0] rx_data;
  logic st_eof, st_err, rxi, irq;

  always #4 clk = ~clk;

  hdlc_rx_extract u_hdlc_rx_extract (
    .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .bit_valid(bit_valid),
    .bit_in(bit_in), .irq_en(irq_en), .rd_data(rd_auto | rd_hold),
    .rx_data(rx_data), .st_eof(st_eof), .st_err(st_err), .rxi(rxi), .irq(irq));

  int checks = 0, fails = 0, got_n = 0, exp_n = 0, tb_ones = 0;
  logic [9:0] got [0:31];
  logic [9:0] expv [0:31];
  logic done = 1'b0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    rd_auto <= rxi && !rd_hold;
    if (rxi && got_n < 32) begin
      got[got_n] = {st_err, st_eof, rx_data};
      got_n++;
      check("R11 irq", {31'd0, irq}, {31'd0, irq_en});
    end
  end

  function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      logic fb;
      fb = c[0] ^ b[i];
      c = {1'b0, c[15:1]};
      if (fb) c = c ^ 16'h8408;
    end
    return c;
  endfunction

  task automatic put_bit(input logic b);
    @(negedge clk); bit_valid = 1'b1; bit_in = b;
    @(negedge clk); bit_valid = 1'b0;
  endtask

  task automatic send_flag();
    for (int i = 0; i < 8; i++) put_bit(i != 0 && i != 7);
    tb_ones = 0;
  endtask

  task automatic send_dbit(input logic b);
    put_bit(b);
    if (b) begin
      tb_ones++;
      if (tb_ones == 5) begin put_bit(1'b0); tb_ones = 0; end
    end else tb_ones = 0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) send_dbit(b[i]);
  endtask

  task automatic send_ones(input int n);
    for (int i = 0; i < n; i++) put_bit(1'b1);
  endtask

  task automatic expect_e(input logic err, input logic eof, input logic [7:0] d);
    expv[exp_n] = {err, eof, d};
    exp_n++;
  endtask

  // sends a frame of n data bytes starting from seed; bad_crc flips one bit, extra adds a bit
  task automatic send_frame(input int n, input logic [7:0] seed, input logic bad_crc,
                            input logic extra, input logic deliver_ok);
    logic [15:0] c;
    logic [7:0] d;
    c = 16'hFFFF;
    send_flag();
    for (int i = 0; i < n; i++) begin
      d = (i == 1) ? 8'hFF : (i == 2) ? 8'h7E : seed + 8'(i * 37);
      c = crc_byte(c, d);
      send_byte(d);
      if (deliver_ok) begin
        if (i < n - 1) expect_e(1'b0, 1'b0, d);
        else expect_e(bad_crc | extra, 1'b1, d);
      end
    end
    c = ~c;
    send_byte(c[7:0] ^ {7'd0, bad_crc});
    send_byte(c[15:8]);
    if (extra) send_dbit(1'b0);
    send_flag();
  endtask

  task automatic settle_compare(input string tag);
    send_flag();
    repeat (6) @(negedge clk);
    check({tag, " count"}, got_n, exp_n);
    for (int i = 0; i < exp_n && i < got_n; i++)
      check({tag, " entry"}, {22'd0, got[i]}, {22'd0, expv[i]});
    got_n = 0; exp_n = 0;
  endtask

  task automatic t_reset();
    check("R1 rxi", {31'd0, rxi}, 0);
    check("R1 irq", {31'd0, irq}, 0);
    check("R1 status", {30'd0, st_err, st_eof}, 0);
    check("R1 data", {24'd0, rx_data}, 0);
  endtask

  task automatic t_disabled();
    rx_enable = 1'b0;
    send_frame(4, 8'h21, 1'b0, 1'b0, 1'b0);
    settle_compare("R12 disabled");
    rx_enable = 1'b1;
  endtask

  task automatic t_good();
    send_flag();
    send_frame(5, 8'h12, 1'b0, 1'b0, 1'b1);
    settle_compare("R3 R4 R5 good frame");
    check("R10 rxi cleared by read", {31'd0, rxi}, 0);
  endtask

  task automatic t_short();
    send_flag(); send_flag(); send_flag();
    send_byte(8'hA5); send_byte(8'h3C);
    send_flag();
    settle_compare("R2 R9 short and idle flags");
  endtask

  task automatic t_badcrc();
    send_frame(4, 8'h40, 1'b1, 1'b0, 1'b1);
    settle_compare("R6 crc error");
  endtask

  task automatic t_misaligned();
    send_frame(4, 8'h05, 1'b0, 1'b1, 1'b1);
    settle_compare("R7 partial byte");
  endtask

  task automatic t_abort_late();
    send_flag();
    send_byte(8'h11); send_byte(8'h22); send_byte(8'h33); send_byte(8'h44); send_byte(8'h55);
    expect_e(1'b0, 1'b0, 8'h11);
    expect_e(1'b0, 1'b0, 8'h22);
    expect_e(1'b1, 1'b1, 8'h00);
    send_ones(10);
    repeat (4) @(negedge clk);
    check("R8 discard until flag", got_n, 3);
    send_frame(3, 8'h60, 1'b0, 1'b0, 1'b1);
    settle_compare("R8 abort after delivery");
  endtask

  task automatic t_abort_early();
    send_flag();
    send_byte(8'h55);
    send_ones(9);
    repeat (4) @(negedge clk);
    settle_compare("R8 silent abort");
  endtask

  task automatic t_collision();
    irq_en = 1'b1;
    rd_hold = 1'b1;
    send_frame(4, 8'h70, 1'b0, 1'b0, 1'b1);
    settle_compare("R10 R11 read on delivery edge");
    rd_hold = 1'b0;
    irq_en = 1'b0;
    @(negedge clk);
    check("R10 rxi after held read", {31'd0, rxi}, 0);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_disabled();
    t_good();
    t_short();
    t_badcrc();
    t_misaligned();
    t_abort_late();
    t_abort_early();
    t_collision();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule